// File: doc/BRIEF.md
# Sequence-Tagged Instruction Injection Buffer

This block replaces the instruction cache of a small single-issue, in-order core while that core runs under randomized verification. A test harness pushes instruction words into a circular store. Each accepted word takes the next sequence number, starting at zero. The fetch stage never presents an address. It names the sequence number it wants, and the block answers with that word and its number. The number then travels with the PC down the pipeline. After a branch, trap or flush, fetch asks again for the number held with the new path. Discarded work is fetched again with no special handling.

A retirement monitor holds the number of the oldest unretired instruction. When a retirement carries exactly that number, the monitor issues one trace entry, advances, and frees the storage slot. Any other number is a sequencing fault. The fault is sticky and stops further trace entries until reset.

Three state machines do the work. The store has no states; it owns the write pointer, the slots and the full test. The fetch responder has two states. In `FT_IDLE` no request is outstanding. In `FT_WAIT` a request names an instruction that has not arrived yet. Its transitions are: `FT_IDLE -> FT_WAIT` when the target is missing, `FT_WAIT -> FT_IDLE` when the target becomes readable, and each state stays put otherwise. The retire monitor has `MON_TRACK` and `MON_FAULT`. It makes one transition, `MON_TRACK -> MON_FAULT`, on a mismatched retirement. `MON_FAULT` only leaves on reset.

Top module: `seqid_inject_buf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `inj_ready`=1, `fetch_rsp_valid`=0, `trace_valid`=0 and `seq_err`=0. It restarts numbering at 0 and discards any outstanding fetch request, so no response appears for a request made before the reset.
- R2: Words accepted on `inj_valid && inj_ready` take consecutive sequence numbers 0, 1, 2, … These numbers wrap modulo 2^ID_W.
- R3: A request (`fetch_req_valid`) for a number already written and not yet retired produces `fetch_rsp_valid`=1 in the next cycle. In that cycle `fetch_rsp_id` equals the requested number, the response carries that instruction, and at most one response is given per cycle.
- R4: When the low two bits of the stored word are not `2'b11`, the response has `fetch_rsp_compressed`=1 and bits 31:16 of `fetch_rsp_insn` are zero. Otherwise `fetch_rsp_compressed`=0 and the full 32-bit word is returned.
- R5: A request for a number not yet written keeps `fetch_rsp_valid` low. If the word is written at clock edge k, the response is valid after edge k+1.
- R6: A new request replaces any outstanding one, so a redirect to an earlier unretired number returns that same instruction again.
- R7: `inj_ready` is low exactly when 2^IDX_W words are held unretired. Words offered while it is low are dropped and consume no number.
- R8: A retirement whose number equals the oldest unretired number gives `trace_valid`=1 with that `trace_id` in the next cycle. It also frees one slot, which `inj_ready` reflects in that same cycle.
- R9: A retirement with any other number, or with no word outstanding, sets `seq_err` and gives no trace entry. `seq_err` stays high until reset, and later retirements give no trace entries.
- R10: With `ret_valid` low, no trace entry is produced and the oldest unretired number does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inj_valid | input | 1 | Harness offers an instruction word |
| inj_insn | input | 32 | Offered instruction word (compressed forms in bits 15:0) |
| inj_ready | output | 1 | Store can accept a word this cycle |
| fetch_req_valid | input | 1 | Fetch requests a sequence number |
| fetch_req_id | input | ID_W | Requested sequence number |
| fetch_rsp_valid | output | 1 | Response valid |
| fetch_rsp_id | output | ID_W | Sequence number of the response |
| fetch_rsp_insn | output | 32 | Returned instruction word |
| fetch_rsp_compressed | output | 1 | Returned word is a 16-bit encoding |
| ret_valid | input | 1 | Pipeline retires an instruction |
| ret_id | input | ID_W | Sequence number of the retiring instruction |
| trace_valid | output | 1 | One trace entry issued |
| trace_id | output | ID_W | Sequence number of the trace entry |
| seq_err | output | 1 | Sticky retirement sequencing fault |

## Verification
The assertions assume that fetch never asks for a number that has already retired. They also assume that the number of words in flight never exceeds half the sequence space, so modular distances stay unambiguous. The stimulus requests only the oldest unretired number or numbers ahead of it. It retires only while at least one word is outstanding, except in the one cycle that deliberately provokes the fault. Its long streaming phase runs past the wrap of the 8-bit sequence space with the 8-entry store.

// File: rtl/seqid_pkg.sv
package seqid_pkg;

    localparam int INSN_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic {
        FT_IDLE = 1'b0,
        FT_WAIT = 1'b1
    } fetch_state_t;

    typedef enum logic {
        MON_TRACK = 1'b0,
        MON_FAULT = 1'b1
    } mon_state_t;

    // A 32-bit encoding always ends in 2'b11; anything else is a 16-bit form.
    function automatic logic is_half(input logic [INSN_W-1:0] w);
        return w[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/seqid_store.sv
module seqid_store
    import seqid_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inj_valid,
    input  logic [INSN_W-1:0] inj_insn,
    output logic              inj_ready,
    input  logic [ID_W-1:0]   rel_ptr,
    output logic [ID_W-1:0]   wr_ptr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [INSN_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [ID_W-1:0] DEPTH_ID = ID_W'(DEPTH);

    logic [INSN_W-1:0] slots [DEPTH];
    logic [ID_W-1:0]   held;
    logic              push;

    always_comb begin
        held      = wr_ptr - rel_ptr;
        inj_ready = held < DEPTH_ID;
        push      = inj_valid && inj_ready;
        rd_data   = slots[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr[IDX_W-1:0]] <= inj_insn;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr - rel_ptr) <= DEPTH_ID); // R7

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_ready) |=> (wr_ptr == $past(wr_ptr))); // R7

endmodule

// File: rtl/seqid_fetch.sv
module seqid_fetch
    import seqid_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ID_W-1:0]   wr_ptr,
    input  logic [ID_W-1:0]   rel_ptr,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [INSN_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [INSN_W-1:0] rsp_insn,
    output logic              rsp_compressed
);

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [ID_W-1:0] DEPTH_ID = ID_W'(DEPTH);

    fetch_state_t    state, state_nx;
    logic [ID_W-1:0] pend_id;
    logic [ID_W-1:0] tgt_id;
    logic [ID_W-1:0] tgt_ofs;
    logic [ID_W-1:0] fill;
    logic            tgt_v;
    logic            hit;

    // Target selection and readability test.
    always_comb begin
        tgt_v   = req_valid || (state == FT_WAIT);
        tgt_id  = req_valid ? req_id : pend_id;
        tgt_ofs = tgt_id - rel_ptr;
        fill    = wr_ptr - rel_ptr;
        hit     = tgt_v && (tgt_ofs < fill);
        rd_idx  = tgt_id[IDX_W-1:0];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FT_IDLE: if (tgt_v && !hit) state_nx = FT_WAIT;
            FT_WAIT: if (hit)           state_nx = FT_IDLE;
            default:                    state_nx = FT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FT_IDLE;
            pend_id <= '0;
        end else begin
            state <= state_nx;
            if (req_valid) pend_id <= req_id;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_id         <= '0;
            rsp_insn       <= '0;
            rsp_compressed <= 1'b0;
        end else begin
            rsp_valid <= hit;
            if (hit) begin
                rsp_id         <= tgt_id;
                rsp_compressed <= is_half(rd_data);
                rsp_insn       <= is_half(rd_data)
                                  ? {{(INSN_W-HALF_W){1'b0}}, rd_data[HALF_W-1:0]}
                                  : rd_data;
            end
        end
    end

    AST_RSP_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((wr_ptr - rsp_id) != '0) && ((wr_ptr - rsp_id) <= DEPTH_ID)); // R5

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == FT_WAIT) |-> !rsp_valid); // R5

    AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_compressed) |-> (rsp_insn[INSN_W-1:HALF_W] == '0)); // R4

endmodule

// File: rtl/seqid_retire.sv
module seqid_retire
    import seqid_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ret_valid,
    input  logic [ID_W-1:0] ret_id,
    input  logic [ID_W-1:0] wr_ptr,
    output logic [ID_W-1:0] exp_id,
    output logic            trace_valid,
    output logic [ID_W-1:0] trace_id,
    output logic            seq_err
);

    mon_state_t state, state_nx;
    logic       good;
    logic       bad;

    always_comb begin
        good = ret_valid && (ret_id == exp_id) && (wr_ptr != exp_id);
        bad  = ret_valid && !good;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MON_TRACK: if (bad) state_nx = MON_FAULT;
            MON_FAULT:          state_nx = MON_FAULT;
            default:            state_nx = MON_TRACK;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= MON_TRACK;
        else     state <= state_nx;
    end

    // Outputs and expected-number counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            exp_id      <= '0;
            trace_valid <= 1'b0;
            trace_id    <= '0;
        end else begin
            trace_valid <= (state == MON_TRACK) && good;
            if ((state == MON_TRACK) && good) begin
                exp_id   <= exp_id + 1'b1;
                trace_id <= exp_id;
            end
        end
    end

    assign seq_err = (state == MON_FAULT);

    AST_TRACE_MATCH: assert property (@(posedge clk) disable iff (rst)
        trace_valid |-> ($past(ret_valid) && ($past(ret_id) == trace_id))); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err); // R9

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(seq_err) |-> !trace_valid); // R9

endmodule

// File: rtl/seqid_inject_buf.sv
module seqid_inject_buf
    import seqid_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inj_valid,
    input  logic [31:0]     inj_insn,
    output logic            inj_ready,
    input  logic            fetch_req_valid,
    input  logic [ID_W-1:0] fetch_req_id,
    output logic            fetch_rsp_valid,
    output logic [ID_W-1:0] fetch_rsp_id,
    output logic [31:0]     fetch_rsp_insn,
    output logic            fetch_rsp_compressed,
    input  logic            ret_valid,
    input  logic [ID_W-1:0] ret_id,
    output logic            trace_valid,
    output logic [ID_W-1:0] trace_id,
    output logic            seq_err
);

    logic [ID_W-1:0]   wr_ptr;
    logic [ID_W-1:0]   exp_id;
    logic [IDX_W-1:0]  rd_idx;
    logic [INSN_W-1:0] rd_data;

    seqid_store #(.ID_W(ID_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .inj_valid (inj_valid),
        .inj_insn  (inj_insn),
        .inj_ready (inj_ready),
        .rel_ptr   (exp_id),
        .wr_ptr    (wr_ptr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    seqid_fetch #(.ID_W(ID_W), .IDX_W(IDX_W)) u_fetch (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (fetch_req_valid),
        .req_id         (fetch_req_id),
        .wr_ptr         (wr_ptr),
        .rel_ptr        (exp_id),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .rsp_valid      (fetch_rsp_valid),
        .rsp_id         (fetch_rsp_id),
        .rsp_insn       (fetch_rsp_insn),
        .rsp_compressed (fetch_rsp_compressed)
    );

    seqid_retire #(.ID_W(ID_W)) u_retire (
        .clk         (clk),
        .rst         (rst),
        .ret_valid   (ret_valid),
        .ret_id      (ret_id),
        .wr_ptr      (wr_ptr),
        .exp_id      (exp_id),
        .trace_valid (trace_valid),
        .trace_id    (trace_id),
        .seq_err     (seq_err)
    );

    AST_IDLE_RETIRE: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> !trace_valid); // R10

endmodule

// File: tb/test_seqid_inject_buf.sv
module test_seqid_inject_buf;

    localparam int ID_W  = 8;
    localparam int IDX_W = 3;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            inj_valid = 1'b0;
    logic [31:0]     inj_insn = '0;
    logic            inj_ready;
    logic            fetch_req_valid = 1'b0;
    logic [ID_W-1:0] fetch_req_id = '0;
    logic            fetch_rsp_valid;
    logic [ID_W-1:0] fetch_rsp_id;
    logic [31:0]     fetch_rsp_insn;
    logic            fetch_rsp_compressed;
    logic            ret_valid = 1'b0;
    logic [ID_W-1:0] ret_id = '0;
    logic            trace_valid;
    logic [ID_W-1:0] trace_id;
    logic            seq_err;

    seqid_inject_buf #(.ID_W(ID_W), .IDX_W(IDX_W)) i_seqid_inject_buf (
        .clk(clk), .rst(rst),
        .inj_valid(inj_valid), .inj_insn(inj_insn), .inj_ready(inj_ready),
        .fetch_req_valid(fetch_req_valid), .fetch_req_id(fetch_req_id),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_id(fetch_rsp_id),
        .fetch_rsp_insn(fetch_rsp_insn), .fetch_rsp_compressed(fetch_rsp_compressed),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .trace_valid(trace_valid), .trace_id(trace_id), .seq_err(seq_err)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string ph = "R1";

    // Behavioural reference model.
    logic [31:0]     m_mem [256];
    logic [ID_W-1:0] m_wr = '0, m_exp = '0, m_pend = '0;
    bit              m_pend_v = 0, m_rsp_v = 0, m_tr_v = 0, m_err = 0, m_rsp_c = 0;
    logic [ID_W-1:0] m_rsp_id = '0, m_tr_id = '0;
    logic [31:0]     m_rsp_w = '0;

    function automatic int m_count();
        return int'(ID_W'(m_wr - m_exp));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_wr = '0; m_exp = '0; m_pend_v = 0; m_pend = '0;
            m_rsp_v = 0; m_tr_v = 0; m_err = 0;
        end else begin
            int              cnt;
            bit              tv;
            logic [ID_W-1:0] tid;
            logic [31:0]     w;
            cnt = m_count();
            tv  = fetch_req_valid || m_pend_v;
            tid = fetch_req_valid ? fetch_req_id : m_pend;
            if (tv && int'(ID_W'(tid - m_exp)) < cnt) begin
                w        = m_mem[tid];
                m_rsp_v  = 1;
                m_rsp_id = tid;
                m_rsp_c  = (w[1:0] != 2'b11);
                m_rsp_w  = m_rsp_c ? {16'h0, w[15:0]} : w;
                m_pend_v = 0;
            end else begin
                m_rsp_v  = 0;
                m_pend_v = tv;
                m_pend   = tid;
            end
            m_tr_v = 0;
            if (ret_valid && !m_err) begin
                if (ret_id == m_exp && cnt > 0) begin
                    m_tr_v  = 1;
                    m_tr_id = m_exp;
                    m_exp   = m_exp + 1'b1;
                end else begin
                    m_err = 1;
                end
            end
            if (inj_valid && cnt < DEPTH) begin
                m_mem[m_wr] = inj_insn;
                m_wr = m_wr + 1'b1;
            end
        end
    end

    task automatic chk(string tag, string what, bit ok, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            bit ready_exp;
            ready_exp = m_count() < DEPTH;
            chk(ph, "inj_ready", inj_ready == ready_exp, inj_ready, ready_exp);
            chk(ph, "fetch_rsp_valid", fetch_rsp_valid == m_rsp_v, fetch_rsp_valid, m_rsp_v);
            if (m_rsp_v && fetch_rsp_valid) begin
                chk("R3", "fetch_rsp_id", fetch_rsp_id == m_rsp_id, fetch_rsp_id, m_rsp_id);
                chk("R3", "fetch_rsp_insn", fetch_rsp_insn == m_rsp_w, fetch_rsp_insn, m_rsp_w);
                chk("R4", "fetch_rsp_compressed", fetch_rsp_compressed == m_rsp_c,
                    fetch_rsp_compressed, m_rsp_c);
            end
            chk(ph, "trace_valid", trace_valid == m_tr_v, trace_valid, m_tr_v);
            if (m_tr_v && trace_valid)
                chk("R8", "trace_id", trace_id == m_tr_id, trace_id, m_tr_id);
            chk("R9", "seq_err", seq_err == m_err, seq_err, m_err);
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    always @(posedge clk) begin
        if (cycles > 50000) begin
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

    function automatic logic [31:0] mk(int i);
        if (i % 3 == 1) return 32'hBEEF_0001 | (32'(i) << 4);
        return 32'h0000_0013 | (32'(i) << 12);
    endfunction

    task automatic cyc(bit iv, logic [31:0] iw, bit fv, logic [ID_W-1:0] fid,
                       bit rv, logic [ID_W-1:0] rid);
        inj_valid = iv; inj_insn = iw;
        fetch_req_valid = fv; fetch_req_id = fid;
        ret_valid = rv; ret_id = rid;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, '0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ph = "R1";
        chk("R1", "reset inj_ready", inj_ready == 1'b1, inj_ready, 1);
        chk("R1", "reset fetch_rsp_valid", fetch_rsp_valid == 1'b0, fetch_rsp_valid, 0);
        chk("R1", "reset trace_valid", trace_valid == 1'b0, trace_valid, 0);
        chk("R1", "reset seq_err", seq_err == 1'b0, seq_err, 0);
        idle(1);

        // R2: numbering and basic fetch with both encodings.
        ph = "R2";
        for (int i = 0; i < 4; i++) cyc(1, mk(i), 0, '0, 0, '0);
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, ID_W'(i), 0, '0);
        idle(2);

        // R5: request ahead of the writer.
        ph = "R5";
        cyc(0, '0, 1, 8'd6, 0, '0);
        idle(3);
        for (int i = 4; i < 7; i++) cyc(1, mk(i), 0, '0, 0, '0);
        idle(3);

        // R6: pending request replaced by a redirect to an earlier number.
        ph = "R6";
        cyc(0, '0, 1, 8'd9, 0, '0);
        cyc(0, '0, 1, 8'd2, 0, '0);
        idle(2);
        cyc(0, '0, 1, 8'd1, 0, '0);
        cyc(0, '0, 1, 8'd1, 0, '0);
        idle(2);

        // R8 and R10: in-order retirement with gaps.
        ph = "R8";
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, '0, 1, ID_W'(i));
        ph = "R10";
        idle(3);

        // R7: fill the store, then offer while full, then free one slot.
        ph = "R7";
        for (int i = 7; i < 14; i++) cyc(1, mk(i), 0, '0, 0, '0);
        cyc(1, 32'hFFFF_FFFF, 0, '0, 0, '0);
        cyc(1, 32'hFFFF_FFFF, 0, '0, 0, '0);
        cyc(0, '0, 0, '0, 1, m_exp);
        cyc(1, mk(20), 0, '0, 0, '0);
        cyc(0, '0, 1, m_wr - 8'd1, 0, '0);
        idle(2);

        // R2 and R8: long stream across the sequence wrap.
        ph = "R2";
        for (int i = 0; i < 600; i++) begin
            if (i % 2 == 0) cyc(1, mk(i + 30), 1, m_exp, 0, '0);
            else            cyc(i % 4 == 1, mk(i + 30), 0, '0, m_count() > 0, m_exp);
        end
        idle(2);

        // R9: out-of-order retirement, then further retirements ignored.
        ph = "R9";
        cyc(1, mk(7), 0, '0, 0, '0);
        cyc(0, '0, 0, '0, 1, m_exp + 8'd3);
        cyc(0, '0, 0, '0, 1, m_exp);
        idle(3);

        // R1: reset drops an outstanding request.
        ph = "R1";
        cyc(0, '0, 1, 8'd2, 0, '0);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk("R1", "post-reset seq_err", seq_err == 1'b0, seq_err, 0);
        for (int i = 0; i < 4; i++) cyc(1, mk(i), 0, '0, 0, '0);
        idle(3);
        chk("R1", "dropped request stays silent", fetch_rsp_valid == 1'b0, fetch_rsp_valid, 0);

        report();
        $finish;
    end

endmodule